// File: doc/BRIEF.md
# Blanked Overcurrent Sample Detector

This block turns a raw high-side current comparator bit into a clean overcurrent event for a synchronous buck controller. The analog front end compares the drop across the conducting upper switch with a programmed threshold drop and delivers the result as a synchronous bit. Switching noise right after turn-on makes that bit unreliable. The detector therefore ignores it for a fixed number of clock cycles after each high-side turn-on. Over the same span, it runs a low-pass check that demands the bit stay high for a run of consecutive samples.

A detection interval is a run of consecutive clock samples in which both the high-side gate is on and the drivers are enabled. Sample index 0 is the first sample of an interval. The block issues at most one single-cycle trip pulse per interval to the downstream fault sequencer. Detection stays inactive until the drivers are enabled. Ending the interval clears all detector state.

Top module: `oc_blank_detect`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, oc_trip_o is 0.
- R2: A sample is active only when hs_on_i and drv_en_i are both 1. With drv_en_i at 0, no pulse is produced whatever hs_on_i and cmp_i do.
- R3: No trip is declared at a sample index below BLANK_CYC (default 12), even if cmp_i has been 1 since index 0.
- R4: A trip at sample index j requires cmp_i = 1 on the FILT_CYC (default 12) samples j-FILT_CYC+1 through j. A single 0 sample restarts the run.
- R5: oc_trip_o is high for exactly one cycle: the cycle after the clock edge that samples the trip index j.
- R6: Within one detection interval, at most one pulse is produced, even if cmp_i remains 1.
- R7: If the interval ends before both windows are satisfied, no pulse is produced. The next interval starts from index 0 with fresh windows.
- R8: If cmp_i first rises at index s and stays high, the trip index is max(BLANK_CYC, s+FILT_CYC-1). The trip is produced only if that index lies inside the interval and inside the high run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_on_i | input | 1 | High-side gate on (level) |
| drv_en_i | input | 1 | Gate drivers enabled |
| cmp_i | input | 1 | 1 when switch drop exceeds threshold drop |
| oc_trip_o | output | 1 | Single-cycle overcurrent pulse |

## Verification
Several boundary cases are hard to reach with ordinary stimulus:
- the trip index landing exactly on the last sample of an interval, or one sample past it;
- a comparator run that ends exactly one sample short of the filter length;
- a comparator run that starts just before blanking expires.

The stimulus reaches all of them by sweeping a small configuration over every combination of interval length, comparator rise index and run width. Each expected pulse cycle is computed arithmetically from those three numbers. Directed cases add a mid-run dip, back-to-back intervals and disabled drivers.

// File: rtl/oc_pkg.sv
package oc_pkg;
  function automatic int cnt_w(input int max_v);
    return (max_v < 1) ? 1 : $clog2(max_v + 1);
  endfunction
endpackage

// File: rtl/oc_sat_cnt.sv
module oc_sat_cnt #(
  parameter int MAX_CNT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic full_o,
  output logic full_next_o
);
  localparam int W = oc_pkg::cnt_w(MAX_CNT);
  localparam logic [W-1:0] MAX_V = W'(MAX_CNT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr_i)             cnt_d = '0;
    else if (cnt_q < MAX_V) cnt_d = cnt_q + W'(1);
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign full_o      = (cnt_q == MAX_V);
  assign full_next_o = (cnt_d == MAX_V);
endmodule

// File: rtl/oc_trip_gate.sv
module oc_trip_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic blank_done_i,
  input  logic filt_ok_i,
  output logic trip_o
);
  logic fired_q, trip_q, hit;

  assign hit = active_i & blank_done_i & filt_ok_i & ~fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      trip_q  <= 1'b0;
    end else begin
      fired_q <= active_i & (fired_q | hit);
      trip_q  <= hit;
    end
  end

  assign trip_o = trip_q;
endmodule

// File: rtl/oc_blank_detect.sv
module oc_blank_detect #(
  parameter int BLANK_CYC = 12,
  parameter int FILT_CYC  = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_on_i,
  input  logic drv_en_i,
  input  logic cmp_i,
  output logic oc_trip_o
);
  logic active;
  logic blank_done, blank_done_nx;
  logic filt_full, filt_ok;

  assign active = hs_on_i & drv_en_i;

  // blanking: full once BLANK_CYC active samples have passed
  oc_sat_cnt #(.MAX_CNT(BLANK_CYC)) u_blank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~active),
    .full_o     (blank_done),
    .full_next_o(blank_done_nx)
  );

  // filter: runs alongside blanking, cleared by any low comparator sample
  oc_sat_cnt #(.MAX_CNT(FILT_CYC)) u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~(active & cmp_i)),
    .full_o     (filt_full),
    .full_next_o(filt_ok)
  );

  oc_trip_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .blank_done_i(blank_done),
    .filt_ok_i   (filt_ok),
    .trip_o      (oc_trip_o)
  );

  logic unused_ok;
  assign unused_ok = blank_done_nx ^ filt_full;
endmodule

// File: rtl/oc_blank_detect_chk.sv
module oc_blank_detect_chk #(
  parameter int BLANK_CYC = 12,
  parameter int FILT_CYC  = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hs_on_i,
  input logic drv_en_i,
  input logic cmp_i,
  input logic oc_trip_o
);
  logic act;
  int   run_q, cmp_run_q;
  logic seen_q;

  assign act = hs_on_i & drv_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 0;
      cmp_run_q <= 0;
      seen_q    <= 1'b0;
    end else begin
      run_q     <= !act ? 0 : (run_q > BLANK_CYC ? run_q : run_q + 1);
      cmp_run_q <= !(act && cmp_i) ? 0 : (cmp_run_q >= FILT_CYC ? cmp_run_q : cmp_run_q + 1);
      seen_q    <= act & (seen_q | oc_trip_o);
    end
  end

  p_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_trip_o |=> !oc_trip_o);
  p_needs_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_trip_o |-> $past(hs_on_i && drv_en_i));
  p_blanked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_trip_o |-> (run_q > BLANK_CYC));
  p_filtered_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_trip_o |-> (cmp_run_q >= FILT_CYC));
  p_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_trip_o |-> !seen_q);
endmodule

bind oc_blank_detect oc_blank_detect_chk #(
  .BLANK_CYC(BLANK_CYC),
  .FILT_CYC (FILT_CYC)
) u_chk (.*);

// File: tb/tb_oc_blank_detect.sv
module tb_oc_blank_detect;
  localparam int B = 4;
  localparam int F = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hs_on_i = 1'b0;
  logic drv_en_i = 1'b0;
  logic cmp_i = 1'b0;
  logic oc_trip_o;
  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  oc_blank_detect #(.BLANK_CYC(B), .FILT_CYC(F)) dut (.*);

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s oc_trip_o actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one interval of len samples, cmp pattern pat, then 3 idle samples
  task automatic run_case(input string tag, input int len, input logic [31:0] pat, input logic en);
    int run = 0;
    int expj = -1;
    for (int k = 0; k < len; k++) begin
      run = (k < 32 && pat[k]) ? run + 1 : 0;
      if (expj < 0 && k >= B && run >= F) expj = k;
    end
    if (!en) expj = -1;
    for (int k = 0; k <= len + 2; k++) begin
      @(negedge clk_i);
      check(tag, oc_trip_o, (expj >= 0) && (k - 1 == expj));
      hs_on_i  = (k < len);
      drv_en_i = en;
      cmp_i    = (k < 32) ? pat[k] : 1'b0;
    end
    @(negedge clk_i);
    check(tag, oc_trip_o, 1'b0);
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hs_on_i = 1'b1; drv_en_i = 1'b1; cmp_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check("R1", oc_trip_o, 1'b0);
    end
    hs_on_i = 1'b0; cmp_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", oc_trip_o, 1'b0);

    run_case("R2", 20, 32'hFFFF_FFFF, 1'b0);
    run_case("R3", B, 32'hFFFF_FFFF, 1'b1);
    run_case("R4", 12, 32'hFFFF_FFF7, 1'b1);
    run_case("R4", 12, 32'h0000_0F6F, 1'b1);
    run_case("R5", 8, 32'hFFFF_FFFF, 1'b1);
    run_case("R6", 30, 32'hFFFF_FFFF, 1'b1);
    run_case("R7", 6, 32'h0000_0030, 1'b1);
    run_case("R7", 7, 32'h0000_0070, 1'b1);
    run_case("R7", 5, 32'hFFFF_FFFF, 1'b1);
    run_case("R7", 5, 32'hFFFF_FFFF, 1'b1);

    for (int len = 1; len <= 10; len++)
      for (int s = 0; s <= len; s++)
        for (int w = 1; w <= len - s + 1; w++)
          run_case("R8", len, ((32'd1 << w) - 32'd1) << s, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule